// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This unit supplies the fetch address of a small 8-bit processor with a 14-bit address space. It also carries out the control-transfer operations. The unit holds eight 14-bit words in an internal register file, and a 3-bit pointer selects one of them. The selected word is the live program counter and is always visible on `fetch_addr`. A call or restart moves the pointer forward and loads the new word with the destination, so the word it leaves behind still holds the return address. A return moves the pointer back. No stack traffic ever leaves the unit.

The surrounding fetch logic reads the byte at `fetch_addr` and hands it to the unit. An opcode is offered on `opcode` with `op_valid`. Every other fetched byte, whether an operand or an immediate, is offered on `byte_in` with `byte_valid`. The unit decodes the opcode itself and recognises jumps, calls, returns and restarts. The external `cond_true` input says whether the condition of a conditional opcode holds. `pc_inc` pulses in every cycle in which a fetched byte is consumed and the address steps forward.

The controller has three states. ST_IDLE waits for an opcode or a plain byte. An opcode in the jump or call families causes the transition ST_IDLE to ST_LO. An operand byte then causes ST_LO to ST_HI, and a second operand byte causes ST_HI to ST_IDLE, at which point the transfer resolves. Returns, restarts and all other opcodes complete in ST_IDLE and stay there.

Top module: `callstack_unit`

## Requirements
- R1: After reset, `fetch_addr` is 0 and `pc_inc` is low while no byte is offered.
- R2: Each consumed byte (an opcode in ST_IDLE, or `byte_valid` in any state) raises `pc_inc` in that cycle. If no transfer happens, `fetch_addr` is one higher after the next clock edge, and it wraps from 0x3FFF to 0.
- R3: A jump (01xxx100 unconditional, or 01ccc000 with the condition true) is followed by a low operand byte and then a high operand byte. After the high byte, `fetch_addr` becomes {high[5:0], low}. Bits 7:6 of the high byte have no effect.
- R4: A call (01xxx110 unconditional, or 01ccc010 with the condition true) loads `fetch_addr` with its two-byte destination, formed as in R3. The return address kept is the address just after the call's third byte.
- R5: A return (00xxx111 unconditional, or 00ccc011 with the condition true) makes `fetch_addr` equal to the return address of the latest unreturned call or restart, one clock after the opcode.
- R6: A restart 00AAA101 jumps to AAA×8, with all higher bits zero. The return address kept is the address after the restart opcode.
- R7: A conditional jump, call or return whose condition is false moves no stack entry. `fetch_addr` just advances past the opcode and any operand bytes.
- R8: `cond_true` is sampled only in the cycle of the opcode. Changes to it during the operand bytes have no effect.
- R9: While the unit waits for an operand byte (ST_LO or ST_HI), an `op_valid` without `byte_valid` changes neither `fetch_addr` nor the state, and `pc_inc` stays low.
- R10: The stack is circular over eight entries. An eighth unreturned call or restart overwrites the oldest return address, and the returns that follow move the pointer modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | `opcode` holds a fetched opcode byte |
| opcode | input | 8 | Opcode byte read at `fetch_addr` |
| cond_true | input | 1 | Condition of a conditional opcode holds (sampled with the opcode) |
| byte_valid | input | 1 | `byte_in` holds a fetched non-opcode byte |
| byte_in | input | 8 | Operand or immediate byte read at `fetch_addr` |
| fetch_addr | output | 14 | Current program counter (active stack entry) |
| pc_inc | output | 1 | A byte is consumed this cycle and the address steps |

## Verification
Every address result is due exactly one clock edge after the cycle that offers the opcode or the byte. A jump or call destination is therefore due one edge after the high operand byte, and a return or restart result one edge after its opcode. `pc_inc` is combinational and is due within the same cycle as the offered byte. The bench drives each stimulus on a falling edge and checks `pc_inc` shortly afterwards in that same cycle. It queues the expected address, which a monitor pops and compares just after the following rising edge, so each check lands on the cycle where the result first appears.

// File: rtl/csu_pkg.sv
package csu_pkg;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_JMP,
        OPK_CALL,
        OPK_RET,
        OPK_RST
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     is_cond;
    } op_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI
    } csu_state_e;

endpackage

// File: rtl/csu_decode.sv
module csu_decode
    import csu_pkg::*;
(
    input  logic [7:0] opcode,
    output op_dec_t    dec,
    output logic [2:0] vec
);

    assign vec = opcode[5:3];

    always_comb begin
        dec.kind    = OPK_NONE;
        dec.is_cond = 1'b0;
        if (opcode[7:6] == 2'b01) begin
            case (opcode[2:0])
                3'b100: dec.kind = OPK_JMP;
                3'b000: begin dec.kind = OPK_JMP;  dec.is_cond = 1'b1; end
                3'b110: dec.kind = OPK_CALL;
                3'b010: begin dec.kind = OPK_CALL; dec.is_cond = 1'b1; end
                default: dec.kind = OPK_NONE;
            endcase
        end else if (opcode[7:6] == 2'b00) begin
            case (opcode[2:0])
                3'b111: dec.kind = OPK_RET;
                3'b011: begin dec.kind = OPK_RET; dec.is_cond = 1'b1; end
                3'b101: dec.kind = OPK_RST;
                default: dec.kind = OPK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/csu_stack.sv
module csu_stack #(
    parameter int AW    = 14,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cur,
    input  logic [AW-1:0] cur_d,
    input  logic          push,
    input  logic [AW-1:0] push_d,
    input  logic          pop,
    output logic [AW-1:0] top_q
);

    localparam int PW = $clog2(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_nx;

    assign ptr_nx = ptr + PW'(1);
    assign top_q  = mem[ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wr_cur) mem[ptr] <= cur_d;
            if (push) begin
                ptr         <= ptr_nx;
                mem[ptr_nx] <= push_d;
            end else if (pop) begin
                ptr <= ptr - PW'(1);
            end
        end
    end

    AST_PUSH_NEW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top_q == $past(push_d)); // R4
    AST_PUSH_KEEPS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_cur) |=> mem[$past(ptr)] == $past(cur_d)); // R6
    AST_POP_STEPS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> ptr == $past(ptr) - PW'(1)); // R5
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(ptr)); // R7
    AST_NO_PUSH_AND_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R10

endmodule

// File: rtl/callstack_unit.sv
module callstack_unit
    import csu_pkg::*;
#(
    parameter int AW    = 14,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [7:0]    opcode,
    input  logic          cond_true,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    output logic [AW-1:0] fetch_addr,
    output logic          pc_inc
);

    localparam int VEC_SHIFT = 3;
    localparam int PAD_W     = AW - 3 - VEC_SHIFT;

    csu_state_e    state_q, state_d;
    op_kind_e      kind_q;
    logic          taken_q;
    logic [7:0]    lo_q;

    op_dec_t       dec;
    logic [2:0]    vec;
    logic          taken_now;
    logic [AW-1:0] pc_plus;
    logic [AW-1:0] tgt;

    logic          wr_cur, push, pop;
    logic [AW-1:0] cur_d, push_d;

    csu_decode u_dec (
        .opcode (opcode),
        .dec    (dec),
        .vec    (vec)
    );

    csu_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cur (wr_cur),
        .cur_d  (cur_d),
        .push   (push),
        .push_d (push_d),
        .pop    (pop),
        .top_q  (fetch_addr)
    );

    assign pc_plus   = fetch_addr + AW'(1);
    assign tgt       = AW'({byte_in, lo_q});
    assign taken_now = !dec.is_cond || cond_true;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid && (dec.kind == OPK_JMP || dec.kind == OPK_CALL))
                         state_d = ST_LO;
            ST_LO:   if (byte_valid) state_d = ST_HI;
            ST_HI:   if (byte_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= OPK_NONE;
            taken_q <= 1'b0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && op_valid) begin
                kind_q  <= dec.kind;
                taken_q <= taken_now;
            end
            if (state_q == ST_LO && byte_valid) lo_q <= byte_in;
        end
    end

    // outputs and stack controls
    always_comb begin
        pc_inc = 1'b0;
        wr_cur = 1'b0;
        cur_d  = pc_plus;
        push   = 1'b0;
        push_d = tgt;
        pop    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    pc_inc = 1'b1;
                    wr_cur = 1'b1;
                    if (dec.kind == OPK_RET) begin
                        pop = taken_now;
                    end else if (dec.kind == OPK_RST) begin
                        push   = 1'b1;
                        push_d = {{PAD_W{1'b0}}, vec, {VEC_SHIFT{1'b0}}};
                    end
                end else if (byte_valid) begin
                    pc_inc = 1'b1;
                    wr_cur = 1'b1;
                end
            end
            ST_LO: begin
                if (byte_valid) begin
                    pc_inc = 1'b1;
                    wr_cur = 1'b1;
                end
            end
            ST_HI: begin
                if (byte_valid) begin
                    pc_inc = 1'b1;
                    wr_cur = 1'b1;
                    if (taken_q && kind_q == OPK_JMP) cur_d = tgt;
                    else if (taken_q && kind_q == OPK_CALL) push = 1'b1;
                end
            end
            default: ;
        endcase
    end

    AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO && byte_valid) |=> fetch_addr == $past(fetch_addr) + AW'(1)); // R2
    AST_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && op_valid && !byte_valid) |=> $stable(fetch_addr) && state_q == $past(state_q)); // R9
    AST_RST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_valid && dec.kind == OPK_RST) |=> fetch_addr[2:0] == 3'b000 && fetch_addr[AW-1:6] == '0); // R6
    AST_FALSE_COND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI && byte_valid && !taken_q) |=> fetch_addr == $past(fetch_addr) + AW'(1)); // R7
    AST_NO_INC_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !byte_valid) |-> !pc_inc); // R9

endmodule

// File: tb/test_callstack_unit.sv
`timescale 1ns/100ps
module test_callstack_unit;

    localparam int K_NONE = 0, K_JMP = 1, K_CALL = 2, K_RET = 3, K_RST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic        cond_true = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [13:0] fetch_addr;
    logic        pc_inc;

    always #2.5 clk = ~clk;

    callstack_unit i_callstack_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .cond_true(cond_true), .byte_valid(byte_valid), .byte_in(byte_in),
        .fetch_addr(fetch_addr), .pc_inc(pc_inc)
    );

    typedef struct {
        logic [13:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // reference model of the requirements
    logic [13:0] m_mem [8];
    int          m_ptr = 0;
    int          m_st = 0;
    int          m_kind = 0;
    bit          m_taken = 1'b0;
    logic [7:0]  m_lo = '0;

    initial for (int i = 0; i < 8; i++) m_mem[i] = '0;

    // monitor: compare the address due one edge after each stimulus
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (fetch_addr !== it.addr) begin
                n_fail++;
                $display("FAIL %s: fetch_addr actual %h expected %h", it.tag, fetch_addr, it.addr);
            end
        end
    end

    task automatic apply(input bit is_op, input logic [7:0] opc, input int kind,
                         input bit is_cond, input bit cnd, input bit bv,
                         input logic [7:0] b, input string tag);
        bit exp_inc;
        @(negedge clk);
        op_valid = is_op; opcode = opc; cond_true = cnd;
        byte_valid = bv;  byte_in = b;
        exp_inc = 1'b0;
        if (m_st == 0) begin
            if (is_op) begin
                exp_inc = 1'b1;
                m_mem[m_ptr] = m_mem[m_ptr] + 14'd1;
                m_taken = !is_cond || cnd;
                m_kind  = kind;
                if (kind == K_JMP || kind == K_CALL) m_st = 1;
                else if (kind == K_RET && m_taken) m_ptr = (m_ptr + 7) % 8;
                else if (kind == K_RST) begin
                    m_ptr = (m_ptr + 1) % 8;
                    m_mem[m_ptr] = {8'b0, opc[5:3], 3'b000};
                end
            end else if (bv) begin
                exp_inc = 1'b1;
                m_mem[m_ptr] = m_mem[m_ptr] + 14'd1;
            end
        end else if (bv) begin
            exp_inc = 1'b1;
            m_mem[m_ptr] = m_mem[m_ptr] + 14'd1;
            if (m_st == 1) begin
                m_lo = b;
                m_st = 2;
            end else begin
                m_st = 0;
                if (m_taken && m_kind == K_JMP) m_mem[m_ptr] = {b[5:0], m_lo};
                else if (m_taken && m_kind == K_CALL) begin
                    m_ptr = (m_ptr + 1) % 8;
                    m_mem[m_ptr] = {b[5:0], m_lo};
                end
            end
        end
        exp_q.push_back('{m_mem[m_ptr], tag});
        #1;
        n_chk++;
        if (pc_inc !== exp_inc) begin
            n_fail++;
            $display("FAIL %s: pc_inc actual %b expected %b", tag, pc_inc, exp_inc);
        end
        @(posedge clk);
        #1;
        op_valid = 1'b0; byte_valid = 1'b0;
    endtask

    task automatic t_op(input logic [7:0] opc, input int kind, input bit is_cond,
                        input bit cnd, input string tag);
        apply(1'b1, opc, kind, is_cond, cnd, 1'b0, 8'h00, tag);
    endtask

    task automatic t_byte(input logic [7:0] b, input bit cnd, input string tag);
        apply(1'b0, 8'h00, K_NONE, 1'b0, cnd, 1'b1, b, tag);
    endtask

    task automatic check_addr(input logic [13:0] e, input string tag);
        @(negedge clk);
        n_chk++;
        if (fetch_addr !== e) begin
            n_fail++;
            $display("FAIL %s: fetch_addr actual %h expected %h", tag, fetch_addr, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run not finished, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_addr(14'h0000, "R1 reset address");
        n_chk++;
        if (pc_inc !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pc_inc actual %b expected 0", pc_inc);
        end

        // R2 plain fetches step the address
        t_op(8'hC0, K_NONE, 0, 0, "R2 plain opcode");
        t_op(8'h81, K_NONE, 0, 0, "R2 plain opcode 2");
        t_byte(8'h55, 0, "R2 immediate byte");
        check_addr(14'h0003, "R2 after three bytes");

        // R3 jump, top two bits of high byte ignored
        t_op(8'h44, K_JMP, 0, 0, "R3 jump opcode");
        t_byte(8'h00, 0, "R3 low byte");
        t_byte(8'hFF, 0, "R3 high byte");
        check_addr(14'h3F00, "R3 masked target");

        // R2 wrap at top of space
        t_op(8'h7C, K_JMP, 0, 0, "R3 jump to top");
        t_byte(8'hFF, 0, "R3 low byte");
        t_byte(8'h3F, 0, "R3 high byte");
        check_addr(14'h3FFF, "R3 top address");
        t_op(8'hC8, K_NONE, 0, 0, "R2 wrap to zero");
        check_addr(14'h0000, "R2 wrapped address");

        // R4 call and R5 return
        t_op(8'h46, K_CALL, 0, 0, "R4 call opcode");
        t_byte(8'h34, 0, "R4 low byte");
        t_byte(8'h12, 0, "R4 high byte");
        check_addr(14'h1234, "R4 call target");
        t_op(8'hC1, K_NONE, 0, 0, "R2 inside routine");
        t_op(8'h07, K_RET, 0, 0, "R5 return");
        check_addr(14'h0003, "R5 return address");

        // R7 false conditions
        t_op(8'h40, K_JMP, 1, 0, "R7 cond jump false");
        t_byte(8'h00, 0, "R7 low byte");
        t_byte(8'h20, 0, "R7 high byte");
        check_addr(14'h0006, "R7 fall through jump");
        t_op(8'h0B, K_RET, 1, 0, "R7 cond return false");
        check_addr(14'h0007, "R7 fall through return");

        // R8 condition sampled with opcode only
        t_op(8'h62, K_CALL, 1, 1, "R8 cond call true");
        t_byte(8'h00, 0, "R8 cond drops on low");
        t_byte(8'h01, 0, "R8 cond drops on high");
        check_addr(14'h0100, "R8 call taken");
        t_op(8'h1B, K_RET, 1, 1, "R5 cond return true");
        check_addr(14'h000A, "R5 cond return address");
        t_op(8'h58, K_JMP, 1, 0, "R8 cond jump false");
        t_byte(8'h99, 1, "R8 cond rises on low");
        t_byte(8'h02, 1, "R8 cond rises on high");
        check_addr(14'h000D, "R8 jump not taken");

        // R9 opcode offered while awaiting operand
        t_op(8'h44, K_JMP, 0, 0, "R9 jump opcode");
        t_op(8'h07, K_RET, 0, 0, "R9 ignored in low wait");
        t_byte(8'h10, 0, "R9 low byte");
        t_op(8'h2D, K_RST, 0, 0, "R9 ignored in high wait");
        t_byte(8'h05, 0, "R9 high byte");
        check_addr(14'h0510, "R9 jump unaffected");

        // R6 restart
        t_op(8'h2D, K_RST, 0, 0, "R6 restart 5");
        check_addr(14'h0028, "R6 restart target");
        t_op(8'h07, K_RET, 0, 0, "R6 return from restart");
        check_addr(14'h0511, "R6 return address");

        // R10 circular depth: eight nested restarts then eight returns
        for (int k = 0; k < 8; k++)
            t_op({2'b00, 3'(k), 3'b101}, K_RST, 0, 0, "R10 nested restart");
        for (int k = 0; k < 8; k++)
            t_op(8'h3F, K_RET, 0, 0, "R10 unwinding return");
        check_addr(14'h0039, "R10 oldest entry overwritten");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule